// File: doc/BRIEF.md
# Exception Frame Sequencer

This block sits beside the control unit of a 32-bit processor and builds exception frames on the supervisor stack, one memory access at a time. On an exception it computes the entry status word and picks a frame layout from the vector number. It then pushes the frame below the stack pointer and fetches the handler address from the vector table. When it finishes it reports the new status word, the new stack pointer and the handler PC.

The same sequencer also undoes a frame on return from exception. It reads the saved status word, the return PC and the format word. From the format it works out how many extra bytes to step over. A format 1 (throwaway) frame is committed, and the unstack then begins again from the new stack pointer. All memory traffic goes through a request/acknowledge port carrying 16-bit or 32-bit big-endian accesses.

Top module: `exc_frame_seq`

## Requirements
- R1: On exception entry the new status word is the old one with bit 13 (supervisor) set and bits 15 and 14 (trace) cleared. For a hardware interrupt, bits 10:8 (interrupt mask) are replaced by the pending level; otherwise the mask is kept.
- R2: With the default configuration (unaligned data not supported), bit 0 of the stack pointer is cleared before the first push. Every push goes to a lower address than the one before it.
- R3: A frame is written downward in this order: the extra longwords, then a 16-bit format word, then the 32-bit return PC, then the 16-bit old status word. The format word holds the format code in bits 15:12 and the vector number times 4 in bits 11:0. The reported stack pointer is the address of the status word.
- R4: Frame layout depends on the vector. Vector 3 uses format 2, with the fault address as its extra longword. Vectors 4, 5, 6, 7 and 9 use format 2, with the current PC as the extra longword. Vector 11 uses format 4, with the current PC pushed first and the fault address below it. Every other vector uses format 0, with no extra longwords.
- R5: For vectors 32 to 47 the saved return PC is the current PC plus 2. For all other vectors it is the current PC.
- R6: This requirement covers a hardware interrupt on vectors 24 to 31 taken while old status bit 12 (master) is set. A format 0 frame holding the old status word is pushed first. Directly below it goes a format 1 frame holding the entry status word. The final status word is the entry word with bit 12 cleared.
- R7: After the pushes, the handler PC is read as a longword from the vector base plus the vector number times 4.
- R8: On return, the block reads the status word at SP, the PC longword at SP+2 and the format word at SP+6. The new SP is SP+8 plus a skip that depends on the format code: 0 for format 0, 4 for formats 2 and 3, 8 for format 4, and 52 for format 7.
- R9: On return, format code 1 commits SP+8 and the read status word. The unstack then restarts from SP+8, and the result comes from the frame found there.
- R10: On return, any other format code leaves SP just past the format word and sets fmt_err. The next accepted start clears fmt_err.
- R11: Each acknowledged access advances the sequence by exactly one transaction. mem_req, mem_addr, mem_we, mem_long and mem_wdata hold steady until mem_ack arrives. done is a single-cycle pulse. No access is requested while busy is low. A start seen while busy is ignored.
- R12: Word accesses (mem_long low) carry their data in bits 15:0 of the data buses. Longword accesses use all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_exc | input | 1 | Begin building an exception frame |
| start_rte | input | 1 | Begin unwinding a frame |
| vec_num | input | VEC_W | Exception vector number |
| hw_irq | input | 1 | Exception is a hardware interrupt |
| irq_level | input | LVL_W | Pending interrupt level |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Current PC |
| sp_in | input | AW | Current stack pointer |
| fault_addr | input | AW | Faulting address for frames that carry one |
| vbr | input | AW | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_long | output | 1 | Access is 32-bit (else 16-bit) |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Last return met an unknown format |
| sr_out | output | 16 | Resulting status word |
| sp_out | output | AW | Resulting stack pointer |
| pc_out | output | 32 | Handler PC or return PC |

## Verification
Some properties can be judged from the ports alone, and the assertions check these on every cycle: request stability until acknowledge, the single-cycle done, a silent bus while idle, even push addresses, strictly descending pushes, the supervisor and trace bits of every entry status word, and fmt_err never following an exception. Other results depend on what is in memory, and only the bench scenarios can show them. These are the exact frame contents for every vector, the trap return offset, the two-frame interrupt case, the skip amount for all sixteen return formats, the throwaway restart and the ignoring of starts while busy.

// File: rtl/exfs_pkg.sv
package exfs_pkg;
   localparam int SR_T1     = 15;
   localparam int SR_T0     = 14;
   localparam int SR_S      = 13;
   localparam int SR_M      = 12;
   localparam int SR_IPL_LO = 8;

   typedef enum logic [3:0] {
      ST_IDLE, ST_XPC, ST_XADR, ST_FMTW, ST_RPC, ST_OSR, ST_VEC,
      ST_RSR, ST_RPCR, ST_RFMT
   } exfs_state_e;

   typedef struct packed {
      logic [3:0] fmt;
      logic       ext_pc;
      logic       ext_adr;
      logic       adr_is_pc;
      logic       nested;
      logic       trap;
   } exfs_plan_t;
endpackage

// File: rtl/exfs_sr_calc.sv
module exfs_sr_calc #(
   parameter int LVL_W = 3
) (
   input  logic [15:0]      sr_old,
   input  logic             hw_irq,
   input  logic [LVL_W-1:0] level,
   output logic [15:0]      sr_entry
);
   import exfs_pkg::*;

   always_comb begin
      sr_entry        = sr_old;
      sr_entry[SR_S]  = 1'b1;
      sr_entry[SR_T1] = 1'b0;
      sr_entry[SR_T0] = 1'b0;
      if (hw_irq) sr_entry[SR_IPL_LO +: 3] = 3'(level);
   end
endmodule

// File: rtl/exfs_plan.sv
module exfs_plan #(
   parameter int VEC_W = 8
) (
   input  logic [VEC_W-1:0]    vec,
   input  logic                hw_irq,
   input  logic                sr_m,
   output exfs_pkg::exfs_plan_t plan
);
   logic [31:0] v;
   assign v = 32'(vec);

   always_comb begin
      plan      = '0;
      plan.trap = (v >= 32'd32) && (v <= 32'd47);
      if (hw_irq && sr_m && (v >= 32'd24) && (v <= 32'd31)) begin
         plan.nested = 1'b1;
      end else begin
         case (v)
            32'd3: begin
               plan.fmt = 4'd2; plan.ext_adr = 1'b1;
            end
            32'd4, 32'd5, 32'd6, 32'd7, 32'd9: begin
               plan.fmt = 4'd2; plan.ext_adr = 1'b1; plan.adr_is_pc = 1'b1;
            end
            32'd11: begin
               plan.fmt = 4'd4; plan.ext_pc = 1'b1; plan.ext_adr = 1'b1;
            end
            default: plan.fmt = 4'd0;
         endcase
      end
   end
endmodule

// File: rtl/exfs_skip.sv
module exfs_skip (
   input  logic [3:0] fmt,
   output logic [5:0] skip,
   output logic       restart,
   output logic       unknown
);
   always_comb begin
      skip    = 6'd0;
      restart = 1'b0;
      unknown = 1'b0;
      case (fmt)
         4'd0:       skip = 6'd0;
         4'd1:       restart = 1'b1;
         4'd2, 4'd3: skip = 6'd4;
         4'd4:       skip = 6'd8;
         4'd7:       skip = 6'd52;
         default:    unknown = 1'b1;
      endcase
   end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq #(
   parameter int AW           = 32,
   parameter int VEC_W        = 8,
   parameter int LVL_W        = 3,
   parameter bit UNALIGNED_OK = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_exc,
   input  logic             start_rte,
   input  logic [VEC_W-1:0] vec_num,
   input  logic             hw_irq,
   input  logic [LVL_W-1:0] irq_level,
   input  logic [15:0]      sr_in,
   input  logic [31:0]      pc_in,
   input  logic [AW-1:0]    sp_in,
   input  logic [AW-1:0]    fault_addr,
   input  logic [AW-1:0]    vbr,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_long,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_wdata,
   input  logic             mem_ack,
   input  logic [31:0]      mem_rdata,
   output logic             busy,
   output logic             done,
   output logic             fmt_err,
   output logic [15:0]      sr_out,
   output logic [AW-1:0]    sp_out,
   output logic [31:0]      pc_out
);
   import exfs_pkg::*;

   localparam logic [AW-1:0] W_BYTES = AW'(2);
   localparam logic [AW-1:0] L_BYTES = AW'(4);

   if (AW < 16 || AW > 32) begin : g_bad_aw
      $error("exc_frame_seq: AW must lie in 16..32");
   end
   if (VEC_W < 6 || VEC_W > 10) begin : g_bad_vw
      $error("exc_frame_seq: VEC_W must lie in 6..10");
   end
   if (LVL_W != 3) begin : g_bad_lw
      $error("exc_frame_seq: LVL_W must be 3");
   end

   exfs_state_e      st;
   logic [AW-1:0]    sp_q, fa_q, vbr_q, sp_start;
   logic [VEC_W-1:0] vec_q;
   logic [31:0]      pc_q, rpc_q, rd_pc_q;
   logic [15:0]      sr_ent_q, frame_sr_q, rd_sr_q, sr_fin;
   logic [3:0]       frame_fmt_q;
   logic             second_q, done_q, err_q;
   exfs_plan_t       plan_q, plan_c;
   logic [15:0]      sr_ent_c;
   logic [5:0]       skip_c;
   logic             restart_c, unknown_c;

   exfs_sr_calc #(.LVL_W(LVL_W)) u_sr (
      .sr_old(sr_in), .hw_irq(hw_irq), .level(irq_level), .sr_entry(sr_ent_c));

   exfs_plan #(.VEC_W(VEC_W)) u_plan (
      .vec(vec_num), .hw_irq(hw_irq), .sr_m(sr_in[SR_M]), .plan(plan_c));

   exfs_skip u_skip (
      .fmt(mem_rdata[15:12]), .skip(skip_c), .restart(restart_c), .unknown(unknown_c));

   if (UNALIGNED_OK) begin : g_sp_raw
      assign sp_start = sp_in;
   end else begin : g_sp_even
      assign sp_start = {sp_in[AW-1:1], 1'b0};
   end

   always_comb begin
      sr_fin       = sr_ent_q;
      sr_fin[SR_M] = sr_ent_q[SR_M] & ~plan_q.nested;
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_long  = 1'b0;
      mem_addr  = sp_q;
      mem_wdata = '0;
      case (st)
         ST_XPC: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_long = 1'b1;
            mem_addr = sp_q - L_BYTES; mem_wdata = pc_q;
         end
         ST_XADR: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_long = 1'b1;
            mem_addr = sp_q - L_BYTES;
            mem_wdata = plan_q.adr_is_pc ? pc_q : 32'(fa_q);
         end
         ST_FMTW: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = sp_q - W_BYTES;
            mem_wdata = {16'h0000, frame_fmt_q, 12'({vec_q, 2'b00})};
         end
         ST_RPC: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_long = 1'b1;
            mem_addr = sp_q - L_BYTES; mem_wdata = rpc_q;
         end
         ST_OSR: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = sp_q - W_BYTES; mem_wdata = {16'h0000, frame_sr_q};
         end
         ST_VEC: begin
            mem_req = 1'b1; mem_long = 1'b1;
            mem_addr = vbr_q + AW'({vec_q, 2'b00});
         end
         ST_RSR:  mem_req = 1'b1;
         ST_RPCR: begin mem_req = 1'b1; mem_long = 1'b1; end
         ST_RFMT: mem_req = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         sp_q <= '0; fa_q <= '0; vbr_q <= '0; vec_q <= '0;
         pc_q <= '0; rpc_q <= '0; rd_pc_q <= '0;
         sr_ent_q <= '0; frame_sr_q <= '0; rd_sr_q <= '0;
         frame_fmt_q <= '0; second_q <= 1'b0; plan_q <= '0;
         done_q <= 1'b0; err_q <= 1'b0;
         sr_out <= '0; sp_out <= '0; pc_out <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start_exc) begin
                  sp_q        <= sp_start;
                  fa_q        <= fault_addr;
                  vbr_q       <= vbr;
                  vec_q       <= vec_num;
                  pc_q        <= pc_in;
                  rpc_q       <= plan_c.trap ? pc_in + 32'd2 : pc_in;
                  sr_ent_q    <= sr_ent_c;
                  frame_sr_q  <= sr_in;
                  frame_fmt_q <= plan_c.fmt;
                  second_q    <= plan_c.nested;
                  plan_q      <= plan_c;
                  err_q       <= 1'b0;
                  st <= plan_c.ext_pc ? ST_XPC : (plan_c.ext_adr ? ST_XADR : ST_FMTW);
               end else if (start_rte) begin
                  sp_q  <= sp_in;
                  err_q <= 1'b0;
                  st    <= ST_RSR;
               end
            end
            ST_XPC:  if (mem_ack) begin sp_q <= mem_addr; st <= ST_XADR; end
            ST_XADR: if (mem_ack) begin sp_q <= mem_addr; st <= ST_FMTW; end
            ST_FMTW: if (mem_ack) begin sp_q <= mem_addr; st <= ST_RPC;  end
            ST_RPC:  if (mem_ack) begin sp_q <= mem_addr; st <= ST_OSR;  end
            ST_OSR: if (mem_ack) begin
               sp_q <= mem_addr;
               if (second_q) begin
                  second_q    <= 1'b0;
                  frame_fmt_q <= 4'd1;
                  frame_sr_q  <= sr_ent_q;
                  st          <= ST_FMTW;
               end else begin
                  st <= ST_VEC;
               end
            end
            ST_VEC: if (mem_ack) begin
               pc_out <= mem_rdata;
               sp_out <= sp_q;
               sr_out <= sr_fin;
               done_q <= 1'b1;
               st     <= ST_IDLE;
            end
            ST_RSR: if (mem_ack) begin
               rd_sr_q <= mem_rdata[15:0];
               sp_q    <= sp_q + W_BYTES;
               st      <= ST_RPCR;
            end
            ST_RPCR: if (mem_ack) begin
               rd_pc_q <= mem_rdata;
               sp_q    <= sp_q + L_BYTES;
               st      <= ST_RFMT;
            end
            ST_RFMT: if (mem_ack) begin
               sr_out <= rd_sr_q;
               if (restart_c) begin
                  sp_q   <= sp_q + W_BYTES;
                  sp_out <= sp_q + W_BYTES;
                  st     <= ST_RSR;
               end else begin
                  sp_out <= sp_q + W_BYTES + AW'(skip_c);
                  pc_out <= rd_pc_q;
                  err_q  <= unknown_c;
                  done_q <= 1'b1;
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (st != ST_IDLE);
   assign done    = done_q;
   assign fmt_err = err_q;
endmodule

// File: rtl/exfs_chk.sv
module exfs_chk #(
   parameter int AW           = 32,
   parameter bit UNALIGNED_OK = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_exc,
   input logic          start_rte,
   input logic          busy,
   input logic          done,
   input logic          fmt_err,
   input logic [15:0]   sr_out,
   input logic          mem_req,
   input logic          mem_ack,
   input logic          mem_we,
   input logic          mem_long,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata
);
   logic          exc_mode, have_prev;
   logic [AW-1:0] prev_wa;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_mode  <= 1'b0;
         have_prev <= 1'b0;
         prev_wa   <= '0;
      end else begin
         if (!busy) begin
            have_prev <= 1'b0;
            if (start_exc) exc_mode <= 1'b1;
            else if (start_rte) exc_mode <= 1'b0;
         end else if (mem_req && mem_we && mem_ack) begin
            have_prev <= 1'b1;
            prev_wa   <= mem_addr;
         end
      end
   end

   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_long) && $stable(mem_wdata));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   a_r2_descend: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack && have_prev |-> mem_addr < prev_wa);

   a_r1_entry_sr: assert property (@(posedge clk) disable iff (!rst_n)
      done && exc_mode |-> sr_out[13] && !sr_out[15] && !sr_out[14]);

   a_r10_err_rte_only: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_err |-> !exc_mode);

   if (!UNALIGNED_OK) begin : g_even
      a_r2_even_push: assert property (@(posedge clk) disable iff (!rst_n)
         mem_req && mem_we |-> !mem_addr[0]);
   end
endmodule

bind exc_frame_seq exfs_chk #(.AW(AW), .UNALIGNED_OK(UNALIGNED_OK)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_exc(start_exc), .start_rte(start_rte),
   .busy(busy), .done(done), .fmt_err(fmt_err), .sr_out(sr_out),
   .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we), .mem_long(mem_long),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata));

// File: tb/tb_exc_frame_seq.sv
`timescale 1ns/1ps
module tb_exc_frame_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_exc = 1'b0, start_rte = 1'b0;
   logic [7:0]  vec_num = '0;
   logic        hw_irq = 1'b0;
   logic [2:0]  irq_level = '0;
   logic [15:0] sr_in = '0;
   logic [31:0] pc_in = '0, sp_in = '0, fault_addr = '0, vbr = 32'h200;
   logic        mem_req, mem_we, mem_long;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        busy, done, fmt_err;
   logic [15:0] sr_out;
   logic [31:0] sp_out, pc_out;

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   logic [7:0] mem [0:1023];

   always #4 clk = ~clk;

   exc_frame_seq dut (
      .clk(clk), .rst_n(rst_n), .start_exc(start_exc), .start_rte(start_rte),
      .vec_num(vec_num), .hw_irq(hw_irq), .irq_level(irq_level), .sr_in(sr_in),
      .pc_in(pc_in), .sp_in(sp_in), .fault_addr(fault_addr), .vbr(vbr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .fmt_err(fmt_err), .sr_out(sr_out),
      .sp_out(sp_out), .pc_out(pc_out));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   function automatic logic [15:0] rd16(input int a);
      return {mem[a & 1023], mem[(a + 1) & 1023]};
   endfunction
   function automatic logic [31:0] rd32(input int a);
      return {rd16(a), rd16(a + 2)};
   endfunction
   task automatic wr16(input int a, input logic [15:0] d);
      mem[a & 1023] = d[15:8]; mem[(a + 1) & 1023] = d[7:0];
   endtask
   task automatic wr32(input int a, input logic [31:0] d);
      wr16(a, d[31:16]); wr16(a + 2, d[15:0]);
   endtask

   // memory responder: variable latency, one-cycle ack
   initial begin
      int lat = 0, seed = 0;
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (lat == 0) begin
               int a;
               a = int'(mem_addr[9:0]);
               if (mem_we) begin
                  if (mem_long) wr32(a, mem_wdata);
                  else wr16(a, mem_wdata[15:0]);
               end else begin
                  mem_rdata = mem_long ? rd32(a) : {16'h0000, rd16(a)};
               end
               mem_ack = 1'b1;
               seed++;
               lat = seed % 3;
            end else lat--;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL R11 watchdog actual=%h expected=%h", 0, 1);
      report();
   end

   task automatic wait_done();
      int t = 0;
      @(negedge clk);
      while (!done && t < 400) begin @(negedge clk); t++; end
      check("R11 done seen", {31'h0, done}, 32'h1);
   endtask

   task automatic pulse(input bit exc);
      @(negedge clk);
      if (exc) start_exc = 1'b1; else start_rte = 1'b1;
      @(negedge clk);
      start_exc = 1'b0; start_rte = 1'b0;
   endtask

   task automatic chk_frame(input int fmt, input int vec, input logic [31:0] rpc,
                            input logic [15:0] fsr, inout int a);
      a -= 2; check("R3 format word", {16'h0, rd16(a)}, {16'h0, 4'(fmt), 12'(vec * 4)});
      a -= 4; check("R5 return pc", rd32(a), rpc);
      a -= 2; check("R3 saved sr", {16'h0, rd16(a)}, {16'h0, fsr});
   endtask

   task automatic do_exc(input int vec, input bit hw, input int lvl, input logic [15:0] sr,
                         input logic [31:0] pc, input logic [31:0] sp, input logic [31:0] fa);
      logic [15:0] e, fin;
      logic [31:0] rpc;
      int a;
      bit nested;
      for (int i = 'h100; i < 'h200; i++) mem[i] = 8'hEE;
      vec_num = 8'(vec); hw_irq = hw; irq_level = 3'(lvl); sr_in = sr;
      pc_in = pc; sp_in = sp; fault_addr = fa;
      pulse(1);
      wait_done();
      e = (sr | 16'h2000) & 16'h3FFF;
      if (hw) e = (e & 16'hF8FF) | (16'(lvl) << 8);
      nested = hw && sr[12] && vec >= 24 && vec <= 31;
      rpc = (vec >= 32 && vec <= 47) ? pc + 32'd2 : pc;
      a = int'(sp & 32'hFFFF_FFFE);
      fin = e;
      if (nested) begin
         chk_frame(0, vec, rpc, sr, a);
         chk_frame(1, vec, rpc, e, a);   // R6 throwaway frame holds entry SR
         fin = e & 16'hEFFF;
      end else if (vec == 11) begin
         a -= 4; check("R4 fmt4 pc longword", rd32(a), pc);
         a -= 4; check("R4 fmt4 fault longword", rd32(a), fa);
         chk_frame(4, vec, rpc, sr, a);
      end else if (vec == 3) begin
         a -= 4; check("R4 fmt2 fault longword", rd32(a), fa);
         chk_frame(2, vec, rpc, sr, a);
      end else if (vec == 4 || vec == 5 || vec == 6 || vec == 7 || vec == 9) begin
         a -= 4; check("R4 fmt2 pc longword", rd32(a), pc);
         chk_frame(2, vec, rpc, sr, a);
      end else begin
         chk_frame(0, vec, rpc, sr, a);
      end
      check("R2 sp_out", sp_out, 32'(a));
      check("R1 sr_out", {16'h0, sr_out}, {16'h0, fin});
      check("R7 handler pc", pc_out, 32'hC000_0000 | (32'(vec) << 4));
      @(negedge clk);
      check("R11 done single pulse", {31'h0, done}, 32'h0);
   endtask

   initial begin
      int base;
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      for (int v = 0; v < 64; v++) wr32('h200 + v * 4, 32'hC000_0000 | (32'(v) << 4));
      repeat (3) @(negedge clk);
      check("R11 reset busy", {31'h0, busy}, 32'h0);
      check("R11 reset req", {31'h0, mem_req}, 32'h0);
      check("R11 reset done", {31'h0, done}, 32'h0);
      check("R10 reset fmt_err", {31'h0, fmt_err}, 32'h0);
      rst_n = 1'b1;

      // R3 R4 R5 R7: every vector of the small table, odd and even stack pointers
      for (int v = 0; v < 64; v++)
         do_exc(v, 1'b0, 0, 16'hC31F ^ 16'(v), 32'h0010_0000 + 32'(v * 16),
                32'h1F0 | 32'(v & 1), 32'h00AB_0000 + 32'(v));

      // R1 R6: hardware interrupts at each level, master bit clear and set
      for (int l = 1; l < 8; l++)
         for (int m = 0; m < 2; m++)
            do_exc(24 + l, 1'b1, l, 16'h8007 | (16'(m) << 12) | (16'(l) << 4),
                   32'h0200_0000 + 32'(l), 32'h1E3, 32'h0);

      // R8 R9 R10 R12: all sixteen format codes on return
      base = 'h080;
      for (int f = 0; f < 16; f++) begin
         int exp_sp;
         logic [15:0] esr;
         logic [31:0] epc;
         wr16(base, 16'h2700 ^ 16'(f));
         wr32(base + 2, 32'h4000_0000 + 32'(f));
         wr16(base + 6, (16'(f) << 12) | 16'h00A4);
         wr16(base + 8, 16'h0015);
         wr32(base + 10, 32'h5555_0000);
         wr16(base + 14, 16'h0000);
         esr = 16'h2700 ^ 16'(f); epc = 32'h4000_0000 + 32'(f);
         case (f)
            0: exp_sp = base + 8;
            1: begin exp_sp = base + 16; esr = 16'h0015; epc = 32'h5555_0000; end
            2, 3: exp_sp = base + 12;
            4: exp_sp = base + 16;
            7: exp_sp = base + 60;
            default: exp_sp = base + 8;
         endcase
         sp_in = 32'(base);
         pulse(0);
         wait_done();
         check("R8 R9 return sp", sp_out, 32'(exp_sp));
         check("R8 R12 return sr", {16'h0, sr_out}, {16'h0, esr});
         check("R8 return pc", pc_out, epc);
         check("R10 fmt_err", {31'h0, fmt_err},
               (f == 0 || f == 1 || f == 2 || f == 3 || f == 4 || f == 7) ? 32'h0 : 32'h1);
      end

      // R10: error flag cleared by the next start
      do_exc(2, 1'b0, 0, 16'h0000, 32'h0000_1000, 32'h1F0, 32'h0);
      check("R10 fmt_err cleared", {31'h0, fmt_err}, 32'h0);

      // R11: starts while busy are ignored
      vec_num = 8'd5; hw_irq = 1'b0; sr_in = 16'h0000; pc_in = 32'h0000_7000;
      sp_in = 32'h1F0; fault_addr = 32'h0;
      pulse(1);
      vec_num = 8'd40; sp_in = 32'h080; pc_in = 32'h0;
      start_rte = 1'b1; start_exc = 1'b1;
      @(negedge clk);
      start_rte = 1'b0; start_exc = 1'b0;
      wait_done();
      check("R11 ignored start sp", sp_out, 32'h1F0 - 32'd12);
      check("R11 ignored start pc", pc_out, 32'hC000_0050);
      check("R11 ignored start mem", rd32('h1F0 - 4), 32'h0000_7000);

      report();
   end
endmodule